// File: doc/BRIEF.md
# Snapshot-and-clear event counter bank

This block holds sixteen 16-bit event counters, one per group. Each counter advances on a single-cycle increment strobe that marks a received cell for its group. A host reaches the bank through a simple synchronous 8-bit register port. Every group owns a pair of byte registers at adjacent addresses: the low byte at the group's base address and the high byte one address above it.

A host that needs a coherent total writes the snapshot command (0x01) to a group's base address. In one clock the whole 16-bit count moves into a holding register, the live counter restarts, and the group's registers show the held value. Two byte reads then return the count as it stood before the clear. Writing the live command (0x00) to the same address puts the registers back on the running counter. In live view a low-byte read also captures the high byte in a shadow register, so that the following high-byte read cannot see a carry that happened between the two reads.

Top module: `evt_snap_bank`

## Requirements
- R1: After a synchronous active-low reset, every counter, holding register and shadow register is zero, every group is in live view, and `bus_rdata` is 0x00.
- R2: Each increment strobe bit, high for one clock, adds one to its own group's counter only. A strobe held high for N clocks adds N.
- R3: A counter stops at 0xFFFF. Further strobes leave it at 0xFFFF and it never wraps to zero.
- R4: Group g (0..15) has its low byte at base address 0x450 + 0x100*(g/4) + 2*(g%4) and its high byte at that address + 1.
- R5: Writing 0x01 to a group's base address copies the full count into that group's holding register, clears the counter in the same clock, and switches the group to hold view. In hold view the low and high addresses return the held low and high bytes, unaffected by later strobes. Each further 0x01 write takes a new snapshot.
- R6: When a strobe arrives in the same clock as a snapshot write, the held value excludes that event and the counter restarts at 1.
- R7: Writing 0x00 to a group's base address returns that group to live view, and it keeps counting from wherever it stands.
- R8: In live view, a low-byte read returns the counter's low byte and latches its high byte into the shadow register. A high-byte read returns the shadow register, even if the counter has since carried into its high byte.
- R9: Writes of any value other than 0x00 and 0x01, and any write to a high-byte address, change no counter, holding register or view.
- R10: Read data appears on `bus_rdata` in the clock after `bus_rd` is sampled high. Reads of addresses outside the map, and every clock without a read, give 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_inc | input | 16 | Per-group event strobe; bit g counts one event for group g |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, one access per clock |
| bus_wdata | input | 8 | Write data (command value) |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data, valid one clock after the read strobe |

## Verification
On every clock the assertions check the counter rules: single-step advance, the hold at 0xFFFF, the clear on snapshot that restarts at 1 when a strobe coincides, capture of the pre-clear count into the holding register, the mode changes from the two commands, and a zero read bus when no mapped read is under way. Some properties span several host accesses, and only the bench scenarios can show them. These are the snapshot that stays frozen while events keep arriving, the shadow that hides a carry between the low and high reads, commands with other values and writes to high addresses having no effect, and the exact address of each of the sixteen groups. A behavioural model in the bench follows every strobe and access and compares the read bus on each clock.

// File: rtl/snap_pkg.sv
// Package: shared constants and types for the snapshot counter bank.
// Assumes a byte-wide host port and counters exactly two bytes wide.
package snap_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Which value a group's registers present to the host.
    typedef enum logic {
        VIEW_LIVE = 1'b0,
        VIEW_HOLD = 1'b1
    } view_e;
endpackage

// File: rtl/snap_addr_dec.sv
// Module: snap_addr_dec
// Turns a byte address into one-hot low and high register selects per group.
// Groups sit in blocks of GRP_PER_BLK. Each block is BLK_STRIDE apart and
// inside a block the groups are two bytes apart. Assumes the map has no overlaps.
module snap_addr_dec #(
    parameter int NUM_GROUPS  = 16,
    parameter int ADDR_W      = 12,
    parameter int BASE_ADDR   = 'h450,
    parameter int BLK_STRIDE  = 'h100,
    parameter int GRP_PER_BLK = 4
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [NUM_GROUPS-1:0] sel_lo,
    output logic [NUM_GROUPS-1:0] sel_hi
);
    // One comparator pair per group, addresses computed from the map parameters.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_cmp
        localparam int LO_I = BASE_ADDR + (g / GRP_PER_BLK) * BLK_STRIDE
                              + (g % GRP_PER_BLK) * 2;
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_I);
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(LO_I + 1);
        assign sel_lo[g] = (addr == LO_A);
        assign sel_hi[g] = (addr == HI_A);
    end
endmodule

// File: rtl/snap_grp_ctr.sv
// Module: snap_grp_ctr
// One group: a saturating event counter, its snapshot holding register,
// the view mode and the high-byte shadow used for live reads.
// Assumes the decoded strobes from the top are mutually exclusive per clock.
module snap_grp_ctr
    import snap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  inc,
    input  logic  snap_req,
    input  logic  live_req,
    input  logic  rd_lo,
    input  logic  rd_hi,
    output byte_t rd_byte
);
    localparam cnt_t CNT_MAX = '1;

    cnt_t  cnt_q;
    cnt_t  hold_q;
    byte_t shadow_q;
    view_e view_q;

    // Live counter: clear-or-restart on snapshot, otherwise saturating count.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (snap_req)                 cnt_q <= {{(CNT_W-1){1'b0}}, inc};
        else if (inc && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
    end

    // Holding register: takes the pre-clear count on each snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= '0;
        else if (snap_req) hold_q <= cnt_q;
    end

    // View mode: snapshot selects the held value, the live command the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        view_q <= VIEW_LIVE;
        else if (snap_req) view_q <= VIEW_HOLD;
        else if (live_req) view_q <= VIEW_LIVE;
    end

    // Shadow: a live low-byte read freezes the matching high byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                           shadow_q <= '0;
        else if (rd_lo && view_q == VIEW_LIVE) shadow_q <= cnt_q[CNT_W-1:BYTE_W];
    end

    // Byte presented for a read of this group, by view and half.
    always_comb begin
        if (view_q == VIEW_HOLD) rd_byte = rd_hi ? hold_q[CNT_W-1:BYTE_W] : hold_q[BYTE_W-1:0];
        else                     rd_byte = rd_hi ? shadow_q : cnt_q[BYTE_W-1:0];
    end

    // R2: an unblocked strobe advances the count by exactly one.
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !snap_req && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R3: a full counter stays full.
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !snap_req) |=> (cnt_q == CNT_MAX));

    // R5: the snapshot keeps the pre-clear count.
    a_r5_hold_capture: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (hold_q == $past(cnt_q) && view_q == VIEW_HOLD));

    // R5/R6: after a snapshot the counter is 0, or 1 when a strobe coincided.
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (cnt_q == {{(CNT_W-1){1'b0}}, $past(inc)}));

    // R7: the live command restores live view.
    a_r7_live_view: assert property (@(posedge clk) disable iff (!rst_n)
        (live_req && !snap_req) |=> (view_q == VIEW_LIVE));

    // R5: with no snapshot the holding register does not move.
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(hold_q));
endmodule

// File: rtl/evt_snap_bank.sv
// Module: evt_snap_bank (top)
// Bank of per-group snapshot-and-clear event counters behind an 8-bit
// synchronous register port. Decodes commands to each group's base address
// and registers the read data. Assumes at most one of bus_rd/bus_wr per clock.
module evt_snap_bank
    import snap_pkg::*;
#(
    parameter int NUM_GROUPS  = 16,
    parameter int ADDR_W      = 12,
    parameter int BASE_ADDR   = 'h450,
    parameter int BLK_STRIDE  = 'h100,
    parameter int GRP_PER_BLK = 4,
    parameter int CMD_SNAP    = 'h01,
    parameter int CMD_LIVE    = 'h00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_GROUPS-1:0] evt_inc,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [BYTE_W-1:0]     bus_wdata,
    input  logic                  bus_rd,
    output logic [BYTE_W-1:0]     bus_rdata
);
    localparam byte_t SNAP_CODE = BYTE_W'(CMD_SNAP);
    localparam byte_t LIVE_CODE = BYTE_W'(CMD_LIVE);

    logic [NUM_GROUPS-1:0] sel_lo, sel_hi;
    logic [NUM_GROUPS-1:0] snap_req, live_req, rd_lo, rd_hi;
    byte_t                 grp_byte [NUM_GROUPS];
    byte_t                 rd_mux;
    byte_t                 rdata_q;

    snap_addr_dec #(
        .NUM_GROUPS (NUM_GROUPS),
        .ADDR_W     (ADDR_W),
        .BASE_ADDR  (BASE_ADDR),
        .BLK_STRIDE (BLK_STRIDE),
        .GRP_PER_BLK(GRP_PER_BLK)
    ) u_dec (
        .addr  (bus_addr),
        .sel_lo(sel_lo),
        .sel_hi(sel_hi)
    );

    // Per-group strobes and counter instances.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign snap_req[g] = bus_wr && sel_lo[g] && (bus_wdata == SNAP_CODE);
        assign live_req[g] = bus_wr && sel_lo[g] && (bus_wdata == LIVE_CODE);
        assign rd_lo[g]    = bus_rd && sel_lo[g];
        assign rd_hi[g]    = bus_rd && sel_hi[g];

        snap_grp_ctr u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (evt_inc[g]),
            .snap_req(snap_req[g]),
            .live_req(live_req[g]),
            .rd_lo   (rd_lo[g]),
            .rd_hi   (rd_hi[g]),
            .rd_byte (grp_byte[g])
        );
    end

    // Read mux: OR of the selected group's byte, zero when nothing matches.
    always_comb begin
        rd_mux = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (rd_lo[g] || rd_hi[g]) rd_mux = rd_mux | grp_byte[g];
        end
    end

    // Read data register: one clock of latency, zero between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    // R10: without a mapped read the bus returns zero next clock.
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(|rd_lo || |rd_hi) |=> (bus_rdata == '0));

    // R4: an address selects at most one register.
    a_r4_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_lo, sel_hi}));

    // R9: a write to a high-byte address issues no command.
    a_r9_hi_write_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && |sel_hi) |-> (snap_req == '0 && live_req == '0));
endmodule

// File: tb/evt_snap_bank_tb.sv
// Bench for evt_snap_bank: behavioural model compared on every clock, plus
// directed scenarios with expected constants per requirement.
module evt_snap_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_inc = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    // Model state
    int m_cnt [16];
    int m_hold [16];
    int m_shadow [16];
    bit m_view [16];
    bit m_snapped [16];
    int exp_rd = 0;
    int mg;
    bit mhi;

    always #5 clk = ~clk;

    evt_snap_bank u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_inc  (evt_inc),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rd   (bus_rd),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [11:0] lo_addr(input int g);
        return 12'(32'h450 + (g / 4) * 32'h100 + (g % 4) * 2);
    endfunction

    function automatic int find_grp(input logic [11:0] a, output bit hi);
        hi = 1'b0;
        for (int g = 0; g < 16; g++) begin
            if (a == lo_addr(g)) begin hi = 1'b0; return g; end
            if (a == lo_addr(g) + 12'd1) begin hi = 1'b1; return g; end
        end
        return -1;
    endfunction

    // Behavioural model: read with pre-clock state, then commands, then strobes.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < 16; g++) begin
                m_cnt[g] = 0; m_hold[g] = 0; m_shadow[g] = 0; m_view[g] = 0;
            end
            exp_rd = 0;
        end else begin
            for (int g = 0; g < 16; g++) m_snapped[g] = 1'b0;
            exp_rd = 0;
            if (bus_rd) begin
                mg = find_grp(bus_addr, mhi);
                if (mg >= 0) begin
                    if (m_view[mg]) exp_rd = mhi ? (m_hold[mg] >> 8) : (m_hold[mg] & 255);
                    else if (mhi)   exp_rd = m_shadow[mg];
                    else begin
                        exp_rd = m_cnt[mg] & 255;
                        m_shadow[mg] = m_cnt[mg] >> 8;
                    end
                end
            end
            if (bus_wr) begin
                mg = find_grp(bus_addr, mhi);
                if (mg >= 0 && !mhi) begin
                    if (bus_wdata == 8'h01) begin
                        m_hold[mg] = m_cnt[mg];
                        m_cnt[mg] = evt_inc[mg] ? 1 : 0;
                        m_view[mg] = 1'b1;
                        m_snapped[mg] = 1'b1;
                    end else if (bus_wdata == 8'h00) begin
                        m_view[mg] = 1'b0;
                    end
                end
            end
            for (int g = 0; g < 16; g++)
                if (!m_snapped[g] && evt_inc[g] && m_cnt[g] < 65535) m_cnt[g]++;
        end
        cmp_en = 1'b1;
    end

    // Every-clock comparison of the read bus against the model (R10, R2, R8).
    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            checks++;
            if (bus_rdata !== 8'(exp_rd)) begin
                errors++;
                $display("FAIL R10 model compare: actual %02h expected %02h at %0t",
                         bus_rdata, 8'(exp_rd), $time);
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic [15:0] inc = '0);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; evt_inc = inc;
        @(negedge clk);
        bus_wr = 1'b0; evt_inc = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input int g, input int n);
        evt_inc[g] = 1'b1;
        repeat (n) @(negedge clk);
        evt_inc[g] = 1'b0;
    endtask

    task automatic zero_grp(input int g);
        wr(lo_addr(g), 8'h01);
        wr(lo_addr(g), 8'h00);
    endtask

    initial begin : main
        logic [7:0] v;
        logic [7:0] lo;
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", bus_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: all registers read zero after reset.
        for (int g = 0; g < 16; g++) begin
            rd(lo_addr(g), v);       check("R1 low after reset", v, 8'h00);
            rd(lo_addr(g) + 1, v);   check("R1 high after reset", v, 8'h00);
        end
        // R2/R4: each group gets a distinct count, read back at its address.
        for (int g = 0; g < 16; g++) pulse(g, g + 3);
        for (int k = 0; k < 40; k++) begin
            evt_inc = 16'(32'hA5C3 >> (k % 7)) ^ 16'(k * 37);
            @(negedge clk);
        end
        evt_inc = '0;
        for (int g = 0; g < 16; g++) begin
            rd(lo_addr(g), v);
            rd(lo_addr(g) + 1, v);
            check("R4 high byte of small count", v, 8'h00);
        end
        // R2/R4 exact counts after zeroing.
        for (int g = 0; g < 16; g++) zero_grp(g);
        for (int g = 0; g < 16; g++) pulse(g, 2 * g + 1);
        for (int g = 0; g < 16; g++) begin
            rd(lo_addr(g), v); check("R2 R4 per-group count", v, 8'(2 * g + 1));
        end
        // R5: snapshot of 0x12C, frozen while counting continues.
        zero_grp(5);
        pulse(5, 300);
        wr(lo_addr(5), 8'h01);
        pulse(5, 7);
        rd(lo_addr(5), v);     check("R5 held low", v, 8'h2C);
        rd(lo_addr(5) + 1, v); check("R5 held high", v, 8'h01);
        rd(lo_addr(5), v);     check("R5 held low again", v, 8'h2C);
        // R5: second snapshot captures the 7 counted since.
        wr(lo_addr(5), 8'h01);
        rd(lo_addr(5), v);     check("R5 resnapshot low", v, 8'h07);
        // R7: back to live view, counter kept running from 0.
        pulse(5, 4);
        wr(lo_addr(5), 8'h00);
        rd(lo_addr(5), v);     check("R7 live low", v, 8'h04);
        // R6: strobe coincides with snapshot, counter restarts at 1.
        zero_grp(9);
        pulse(9, 10);
        wr(lo_addr(9), 8'h01, 16'h0200);
        rd(lo_addr(9), v);     check("R6 held excludes coincident event", v, 8'h0A);
        wr(lo_addr(9), 8'h00);
        rd(lo_addr(9), v);     check("R6 restart at one", v, 8'h01);
        // R8: carry between low and high reads is hidden by the shadow.
        zero_grp(2);
        pulse(2, 255);
        rd(lo_addr(2), lo);    check("R8 low before carry", lo, 8'hFF);
        pulse(2, 1);
        rd(lo_addr(2) + 1, v); check("R8 high from shadow", v, 8'h00);
        rd(lo_addr(2), v);     check("R8 low after carry", v, 8'h00);
        rd(lo_addr(2) + 1, v); check("R8 high after carry", v, 8'h01);
        // R9: other values and high-address writes change nothing.
        zero_grp(12);
        pulse(12, 20);
        wr(lo_addr(12), 8'h02);
        wr(lo_addr(12), 8'hFF);
        wr(lo_addr(12) + 1, 8'h01);
        wr(lo_addr(12) + 1, 8'h00);
        rd(lo_addr(12), v);    check("R9 ignored writes keep live count", v, 8'h14);
        wr(lo_addr(12), 8'h01);
        wr(lo_addr(12), 8'h03);
        wr(lo_addr(12) + 1, 8'h00);
        pulse(12, 5);
        rd(lo_addr(12), v);    check("R9 ignored writes keep hold view", v, 8'h14);
        // R10: unmapped addresses read zero.
        rd(12'h458, v);        check("R10 unmapped 0x458", v, 8'h00);
        rd(12'h44F, v);        check("R10 unmapped 0x44F", v, 8'h00);
        rd(12'h850, v);        check("R10 unmapped 0x850", v, 8'h00);
        rd(12'h000, v);        check("R10 unmapped 0x000", v, 8'h00);
        @(negedge clk);
        check("R10 idle bus zero", bus_rdata, 8'h00);
        // R3: saturation at 0xFFFF.
        zero_grp(15);
        pulse(15, 65540);
        rd(lo_addr(15), v);     check("R3 saturated low", v, 8'hFF);
        rd(lo_addr(15) + 1, v); check("R3 saturated high", v, 8'hFF);
        wr(lo_addr(15), 8'h01);
        rd(lo_addr(15) + 1, v); check("R3 R5 held full high", v, 8'hFF);
        wr(lo_addr(15), 8'h00);
        rd(lo_addr(15), v);     check("R3 R5 cleared after full", v, 8'h00);
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule